// File: doc/BRIEF.md
# Circular Half/Full Buffer Reader

This block holds a small ring of data words and hands them, one per request, to a serial transmitter. The requests come from an external pacing source, such as a timer that fires on each edge of a word-select signal. The transmitter never asks for data on its own. Each request moves the word at the current read position into an output register and raises a valid strobe. The read position then steps by one and wraps back to the start after the last entry, so reading never stops.

A producer fills the ring through a separate write port. Two event flags tell the producer which half is free to refill. The half flag rises once the last entry of the lower half has gone out. At that point the lower half may be rewritten while the upper half drains. The complete flag rises once the last entry of the upper half has gone out, and then the upper half may be refilled. Each flag has its own enable into a combined interrupt and its own clear input. A global clear drops both flags and the overrun record.

A request can arrive while the previous word is still waiting for the transmitter. Such a request is not served. Instead it is recorded in a sticky overrun flag and a saturating overrun count, so that a pacing fault is always visible.

Top module: `ring_reader`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), tx_valid, half_flag, full_flag, ovr_flag, ovr_count and irq are 0, tx_data is 0, and the first served request reads entry 0.
- R2: A request is served when tx_valid is 0 or tx_ready is 1 at that edge. At the same edge, tx_data takes the entry at the read position and tx_valid becomes 1. The read position then advances by one.
- R3: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data does not change. When tx_ready is 1 and no request is served, tx_valid returns to 0 at that edge.
- R4: After the entry at position DEPTH-1 (31 by default) has been served, the next served request reads entry 0 again. This wrap needs no action from outside.
- R5: half_flag becomes 1 at the edge that serves entry DEPTH/2-1 (entry 15).
- R6: full_flag becomes 1 at the edge that serves entry DEPTH-1 (entry 31).
- R7: clr_half clears half_flag and clr_full clears full_flag. clr_all clears both flags, ovr_flag and ovr_count. If a flag is being set at the same edge as it is cleared, the set wins.
- R8: irq is (half_flag AND en_half) OR (full_flag AND en_full). It follows the flags and enables in the same cycle and stays high until the enabled flags are cleared.
- R9: A request at an edge where tx_valid is 1 and tx_ready is 0 is not served. It sets ovr_flag and adds one to ovr_count, which saturates at its all-ones value. The read position, tx_data and tx_valid are left untouched.
- R10: wr_en writes wr_data into entry wr_addr at the edge. If a request reads the same entry at that same edge, it gets the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Transfer request from the pacing source, one per cycle high |
| tx_ready | input | 1 | Transmitter accepts the presented word |
| wr_en | input | 1 | Producer write strobe |
| wr_addr | input | $clog2(DEPTH) | Entry to write |
| wr_data | input | WIDTH | Word to write |
| clr_half | input | 1 | Clear the half event flag |
| clr_full | input | 1 | Clear the complete event flag |
| clr_all | input | 1 | Clear both flags and the overrun record |
| en_half | input | 1 | Route half flag to irq |
| en_full | input | 1 | Route complete flag to irq |
| tx_data | output | WIDTH | Word presented to the transmitter |
| tx_valid | output | 1 | tx_data holds an unaccepted word |
| half_flag | output | 1 | Lower half has been drained |
| full_flag | output | 1 | Upper half has been drained |
| ovr_flag | output | 1 | At least one request was refused |
| ovr_count | output | OVR_W | Saturating count of refused requests |
| irq | output | 1 | OR of the enabled flags |

## Verification
Two pairs of actions can land on the same edge. A flag can be set by a served request while software pulses its clear, and a producer can write the very entry being read. The bench forces both on purpose. It steps the read position to entry 15 and to entry 31 and pulses the matching clear on the serving request. It also writes the current read position together with a request. The judge is a cycle model that applies set-over-clear and old-data-on-collision. Random traffic then mixes the two collisions with overruns and wraps, and every output is compared on every cycle.

// File: rtl/rr_pkg.sv
// Package rr_pkg
// Shared types for the circular reader. The event pair carries the two
// buffer milestones from the sequencer to the flag logic.
package rr_pkg;
    typedef struct packed {
        logic full;   // last entry of the ring was served
        logic half;   // last entry of the lower half was served
    } rr_evt_t;
endpackage

// File: rtl/rr_store.sv
// Module rr_store
// Word storage for the ring. One synchronous write port for the producer and
// one asynchronous read port for the sequencer. Assumes the reader registers
// the read data, so a same-edge write to the read entry yields the old word.
// The storage has no reset; the producer fills it before reading starts.
module rr_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // Producer write into the addressed entry.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read of the entry at the current read position.
    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/rr_sequencer.sv
// Module rr_sequencer
// Serves paced requests. It holds the read position and the remaining count,
// which reload together after the last entry. It also holds the output
// register and reports the half and complete milestones plus refused
// requests. Assumes req is a single-cycle pulse per request.
module rr_sequencer
    import rr_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     tx_ready,
    input  logic [WIDTH-1:0]         rd_data,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         tx_data,
    output logic                     tx_valid,
    output rr_evt_t                  evt,
    output logic                     ovr_evt
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    logic [AW-1:0]    idx_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH-1:0] data_q;
    logic             valid_q;
    logic             slot_free;
    logic             issue;

    assign slot_free = !valid_q || tx_ready;
    assign issue     = req && slot_free;
    assign ovr_evt   = req && !slot_free;

    // Read position and remaining count step together and reload at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= CW'(DEPTH);
        end else if (issue) begin
            idx_q <= (idx_q == AW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
            cnt_q <= (cnt_q == CW'(1)) ? CW'(DEPTH) : cnt_q - 1'b1;
        end
    end

    // Output register: load on a served request, drop valid on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (issue) begin
            data_q  <= rd_data;
            valid_q <= 1'b1;
        end else if (tx_ready) begin
            valid_q <= 1'b0;
        end
    end

    // The half milestone is taken from the position and the complete one from
    // the count, so each source cross-checks the other.
    assign evt.half = issue && (idx_q == AW'(HALF - 1));
    assign evt.full = issue && (cnt_q == CW'(1));

    assign rd_addr  = idx_q;
    assign tx_data  = data_q;
    assign tx_valid = valid_q;

    // R4: position and remaining count always describe the same point of the lap.
    p_lap_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(idx_q) + 32'(cnt_q)) == DEPTH)
        else $error("p_lap_sync_r4");

    // R2: a served request steps the position by one.
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (idx_q != AW'(DEPTH - 1)) |=> tx_valid && (idx_q == $past(idx_q) + 1'b1))
        else $error("p_advance_r2");

    // R4: serving the last entry brings the position back to zero.
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (idx_q == AW'(DEPTH - 1)) |=> (idx_q == '0))
        else $error("p_wrap_r4");

    // R3: an unaccepted word is held unchanged.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data))
        else $error("p_hold_r3");

    // R9: a refused request leaves the read position alone.
    p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> $stable(idx_q))
        else $error("p_refuse_r9");
endmodule

// File: rtl/rr_events.sv
// Module rr_events
// Sticky milestone flags with individual and global clears, the overrun
// record and the combined interrupt. Assumes a set and a clear at the same
// edge should keep the flag set, so no event is lost.
module rr_events
    import rr_pkg::*;
#(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rr_evt_t          evt,
    input  logic             ovr_evt,
    input  logic             clr_half,
    input  logic             clr_full,
    input  logic             clr_all,
    input  logic             en_half,
    input  logic             en_full,
    output logic             half_flag,
    output logic             full_flag,
    output logic             ovr_flag,
    output logic [OVR_W-1:0] ovr_count,
    output logic             irq
);
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] en_v;
    logic [NFLAG-1:0] flag_v;
    logic             ovr_q;
    logic [OVR_W-1:0] ocnt_q;
    logic [OVR_W-1:0] ocnt_base;

    assign set_v = {evt.full, evt.half};
    assign clr_v = {clr_full | clr_all, clr_half | clr_all};
    assign en_v  = {en_full, en_half};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic q;
        // One sticky flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else if (set_v[g]) begin
                q <= 1'b1;
            end else if (clr_v[g]) begin
                q <= 1'b0;
            end
        end
        assign flag_v[g] = q;
    end

    assign ocnt_base = clr_all ? '0 : ocnt_q;

    // Overrun record: sticky flag and saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q  <= 1'b0;
            ocnt_q <= '0;
        end else begin
            if (ovr_evt) begin
                ovr_q <= 1'b1;
            end else if (clr_all) begin
                ovr_q <= 1'b0;
            end
            if (ovr_evt && (ocnt_base != '1)) begin
                ocnt_q <= ocnt_base + 1'b1;
            end else begin
                ocnt_q <= ocnt_base;
            end
        end
    end

    assign half_flag = flag_v[0];
    assign full_flag = flag_v[1];
    assign ovr_flag  = ovr_q;
    assign ovr_count = ocnt_q;
    assign irq       = |(flag_v & en_v);

    // R5: the half milestone always leaves the half flag set.
    p_half_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt.half |=> half_flag)
        else $error("p_half_set_r5");

    // R6: the complete milestone always leaves the complete flag set.
    p_full_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt.full |=> full_flag)
        else $error("p_full_set_r6");

    // R7: a clear without a competing set drops the flag.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_half && !evt.half |=> !half_flag)
        else $error("p_clear_r7");

    // R9: a refused request is always recorded.
    p_ovr_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovr_flag && (ovr_count != '0))
        else $error("p_ovr_seen_r9");

    // R9: without refusals or a global clear the count stays put.
    p_ovr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_evt && !clr_all |=> $stable(ovr_count))
        else $error("p_ovr_hold_r9");
endmodule

// File: rtl/ring_reader.sv
// Module ring_reader
// Top of the circular half/full buffer reader. It ties storage, sequencer
// and event logic together. Assumes DEPTH is even and at least 4, and that
// the producer fills the ring before the first request.
module ring_reader
    import rr_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    parameter int OVR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     tx_ready,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     clr_half,
    input  logic                     clr_full,
    input  logic                     clr_all,
    input  logic                     en_half,
    input  logic                     en_full,
    output logic [WIDTH-1:0]         tx_data,
    output logic                     tx_valid,
    output logic                     half_flag,
    output logic                     full_flag,
    output logic                     ovr_flag,
    output logic [OVR_W-1:0]         ovr_count,
    output logic                     irq
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0]    rd_addr;
    logic [WIDTH-1:0] rd_data;
    rr_evt_t          evt;
    logic             ovr_evt;

    rr_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rr_sequencer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .tx_ready (tx_ready),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .evt      (evt),
        .ovr_evt  (ovr_evt)
    );

    rr_events #(.OVR_W(OVR_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .ovr_evt   (ovr_evt),
        .clr_half  (clr_half),
        .clr_full  (clr_full),
        .clr_all   (clr_all),
        .en_half   (en_half),
        .en_full   (en_full),
        .half_flag (half_flag),
        .full_flag (full_flag),
        .ovr_flag  (ovr_flag),
        .ovr_count (ovr_count),
        .irq       (irq)
    );

    // R8: a raised interrupt always has an enabled flag behind it.
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (half_flag && en_half) || (full_flag && en_full))
        else $error("p_irq_source_r8");
endmodule

// File: tb/ring_reader_bench.sv
// Bench for ring_reader: directed corner cases plus seeded random traffic,
// compared each cycle against a cycle model built from the requirements.
module ring_reader_bench;
    localparam int  DEPTH = 32;
    localparam int  WIDTH = 16;
    localparam int  OVR_W = 8;
    localparam time CLK_P = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0, tx_ready = 1'b0, wr_en = 1'b0;
    logic [4:0]       wr_addr = '0;
    logic [15:0]      wr_data = '0;
    logic             clr_half = 1'b0, clr_full = 1'b0, clr_all = 1'b0;
    logic             en_half = 1'b0, en_full = 1'b0;
    logic [15:0]      tx_data;
    logic             tx_valid, half_flag, full_flag, ovr_flag, irq;
    logic [OVR_W-1:0] ovr_count;

    int n_cmp = 0;
    int n_bad = 0;

    // Model state.
    logic [15:0] m_mem [DEPTH];
    int          m_idx;
    logic [15:0] m_data;
    logic        m_valid, m_half, m_full, m_ovr;
    int          m_ocnt;

    ring_reader #(.DEPTH(DEPTH), .WIDTH(WIDTH), .OVR_W(OVR_W)) u_ring_reader (
        .clk(clk), .rst_n(rst_n), .req(req), .tx_ready(tx_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_half(clr_half), .clr_full(clr_full), .clr_all(clr_all),
        .en_half(en_half), .en_full(en_full),
        .tx_data(tx_data), .tx_valid(tx_valid), .half_flag(half_flag),
        .full_flag(full_flag), .ovr_flag(ovr_flag), .ovr_count(ovr_count),
        .irq(irq)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_irq();
        return (m_half && en_half) || (m_full && en_full);
    endfunction

    task automatic check_all();
        cmp("R2 tx_data", int'(tx_data), int'(m_data));
        cmp("R3 tx_valid", int'(tx_valid), int'(m_valid));
        cmp("R5 half_flag", int'(half_flag), int'(m_half));
        cmp("R6 full_flag", int'(full_flag), int'(m_full));
        cmp("R9 ovr_flag", int'(ovr_flag), int'(m_ovr));
        cmp("R9 ovr_count", int'(ovr_count), m_ocnt);
        cmp("R8 irq", int'(irq), int'(exp_irq()));
    endtask

    // Applies one cycle of inputs, advances the model across the edge, checks.
    task automatic step(input logic rq, input logic rd, input logic we,
                        input logic [4:0] wa, input logic [15:0] wd,
                        input logic ch, input logic cf, input logic ca);
        logic free, set_h, set_f;
        int   base;
        req = rq; tx_ready = rd; wr_en = we; wr_addr = wa; wr_data = wd;
        clr_half = ch; clr_full = cf; clr_all = ca;
        @(posedge clk);
        free  = !m_valid || rd;
        set_h = 1'b0;
        set_f = 1'b0;
        if (rq && free) begin
            m_data  = m_mem[m_idx];
            m_valid = 1'b1;
            set_h   = (m_idx == DEPTH / 2 - 1);
            set_f   = (m_idx == DEPTH - 1);
            m_idx   = (m_idx + 1) % DEPTH;
        end else if (rd) begin
            m_valid = 1'b0;
        end
        m_half = set_h || (m_half && !(ch || ca));
        m_full = set_f || (m_full && !(cf || ca));
        base   = ca ? 0 : m_ocnt;
        if (rq && !free) begin
            m_ovr  = 1'b1;
            m_ocnt = (base < (1 << OVR_W) - 1) ? base + 1 : base;
        end else begin
            m_ovr  = m_ovr && !ca;
            m_ocnt = base;
        end
        if (we) m_mem[wa] = wd;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        step(1'b0, 1'b1, 1'b0, 5'd0, 16'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic serve_one();
        step(1'b1, 1'b1, 1'b0, 5'd0, 16'd0, 1'b0, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        logic [15:0] old_w;
        unused_seed = $urandom(1234);
        m_idx = 0; m_data = '0; m_valid = 1'b0; m_half = 1'b0; m_full = 1'b0;
        m_ovr = 1'b0; m_ocnt = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

        // Reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs at rest after reset.
        cmp("R1 tx_valid", int'(tx_valid), 0);
        cmp("R1 half_flag", int'(half_flag), 0);
        cmp("R1 full_flag", int'(full_flag), 0);
        cmp("R1 ovr_count", int'(ovr_count), 0);
        cmp("R1 irq", int'(irq), 0);
        cmp("R1 tx_data", int'(tx_data), 0);

        // R10: fill the ring through the write port.
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b0, 1'b1, 5'(i), 16'(i * 997 + 3), 1'b0, 1'b0, 1'b0);

        // R1: first request reads entry 0.
        serve_one();
        cmp("R1 first entry", int'(tx_data), int'(16'(3)));

        // R5/R6/R4: run past the end of the ring with interrupts enabled.
        en_half = 1'b1; en_full = 1'b1;
        for (int i = 1; i < DEPTH; i++) serve_one();
        cmp("R6 full after lap", int'(full_flag), 1);
        serve_one();
        cmp("R4 wrap reads entry 0", int'(tx_data), int'(m_mem[0]));

        // R8: masking and clearing.
        en_half = 1'b0; en_full = 1'b0;
        #1 cmp("R8 irq masked", int'(irq), 0);
        en_full = 1'b1;
        #1 cmp("R8 irq full only", int'(irq), 1);
        step(1'b0, 1'b1, 1'b0, 5'd0, 16'd0, 1'b1, 1'b1, 1'b0);
        cmp("R7 both cleared", int'(half_flag | full_flag), 0);

        // R7: set and clear on the same edge at entry 15, then at entry 31.
        while (m_idx != DEPTH / 2 - 1) serve_one();
        step(1'b1, 1'b1, 1'b0, 5'd0, 16'd0, 1'b1, 1'b0, 1'b0);
        cmp("R7 half set beats clear", int'(half_flag), 1);
        while (m_idx != DEPTH - 1) serve_one();
        step(1'b1, 1'b1, 1'b0, 5'd0, 16'd0, 1'b0, 1'b0, 1'b1);
        cmp("R7 full set beats clr_all", int'(full_flag), 1);
        cmp("R7 half cleared by clr_all", int'(half_flag), 0);

        // R10: write the entry being read at the same edge.
        old_w = m_mem[m_idx];
        step(1'b1, 1'b1, 1'b1, 5'(m_idx), 16'hBEEF, 1'b0, 1'b0, 1'b0);
        cmp("R10 same-edge read gets old", int'(tx_data), int'(old_w));
        cmp("R10 stored new", int'(m_mem[(m_idx + DEPTH - 1) % DEPTH]), int'(16'hBEEF));

        // R9/R3: stalled transmitter, refused requests up to saturation.
        step(1'b0, 1'b0, 1'b0, 5'd0, 16'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++)
            step(1'b1, 1'b0, 1'b0, 5'd0, 16'd0, 1'b0, 1'b0, 1'b0);
        cmp("R9 count saturates", int'(ovr_count), (1 << OVR_W) - 1);
        cmp("R3 word held while stalled", int'(tx_valid), 1);
        step(1'b0, 1'b1, 1'b0, 5'd0, 16'd0, 1'b0, 1'b0, 1'b1);
        cmp("R7 clr_all drops overrun", int'(ovr_flag), 0);
        cmp("R3 valid drops on accept", int'(tx_valid), 0);

        // Random traffic mixing all functions.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) en_half = ~en_half;
            if ($urandom_range(0, 19) == 0) en_full = ~en_full;
            step($urandom_range(0, 9) < 4,
                 $urandom_range(0, 9) < 7,
                 $urandom_range(0, 9) < 3,
                 5'($urandom_range(0, DEPTH - 1)),
                 16'($urandom),
                 $urandom_range(0, 19) == 0,
                 $urandom_range(0, 19) == 0,
                 $urandom_range(0, 39) == 0);
        end
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule